// File: doc/BRIEF.md
# Burst Address Counter Register

This block is the address front end of one port of a synchronous memory. At every rising clock edge it chooses the next internal address in one of four ways. It can clear the address to zero, load the address from the external bus, step the held address up by one, or keep the held address. The chosen value goes into a register, and that register drives the memory array directly.

Three active-low controls select the operation, and they follow a fixed priority. Clear wins over load, and load wins over increment. When none of the three is asserted, the register holds its value and the external bus has no effect. Chip selects and byte selects are not inputs of this block. The counter therefore loads, steps and clears whether or not the port is selected. The address width is a parameter: 12 bits addresses a 4K-deep array and 13 bits an 8K-deep one.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` low and `cnt_clr_n` low at a rising edge, `addr_out` becomes 0, whatever `strobe_n`, `cnt_en_n` and `addr_in` are.
- R3: With `rst` low, `cnt_clr_n` high and `strobe_n` low at a rising edge, `addr_out` takes the value of `addr_in`, whatever `cnt_en_n` is.
- R4: With `rst` low, `cnt_clr_n` and `strobe_n` high and `cnt_en_n` low at a rising edge, `addr_out` becomes its previous value plus one.
- R5: With `rst` low and `cnt_clr_n`, `strobe_n` and `cnt_en_n` all high at a rising edge, `addr_out` keeps its value and `addr_in` has no effect.
- R6: An increment from the all-ones address gives 0. No other output marks the wrap.
- R7: `addr_out` changes only at a rising edge of `clk`. An input change between edges leaves it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the address register |
| addr_in | input | ADDR_W | External address bus |
| strobe_n | input | 1 | Active-low load of `addr_in` |
| cnt_en_n | input | 1 | Active-low counter increment |
| cnt_clr_n | input | 1 | Active-low counter clear to 0 |
| addr_out | output | ADDR_W | Registered internal address to the array |

## Verification
The bench builds the block with `ADDR_W` = 4. With only 16 addresses, random runs of increments reach the all-ones value and wrap to zero many times. Random loads also hit every address value. The priority among clear, load and increment comes from the same logic at any width, so the narrow build still tests the 12- and 13-bit decode.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Operation selected for the next clock edge, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_addr_pkg::*;
(
  input  logic     strobe_n,
  input  logic     cnt_en_n,
  input  logic     cnt_clr_n,
  output addr_op_e op
);

  // Fixed priority: clear, then load, then step, otherwise hold.
  always_comb begin
    if (!cnt_clr_n)      op = OP_CLEAR;
    else if (!strobe_n)  op = OP_LOAD;
    else if (!cnt_en_n)  op = OP_STEP;
    else                 op = OP_HOLD;
  end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  addr_op_e            op,
  input  logic [ADDR_W-1:0]   cur,
  input  logic [ADDR_W-1:0]   ext,
  output logic [ADDR_W-1:0]   nxt
);

  localparam logic [ADDR_W-1:0] ZERO = '0;
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  logic [ADDR_W-1:0] stepped;

  // Modulo-2^ADDR_W increment: the carry out of the top bit is dropped.
  assign stepped = cur + ONE;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = stepped;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_n,
  input  logic              cnt_en_n,
  input  logic              cnt_clr_n,
  output logic [ADDR_W-1:0] addr_out
);

  addr_op_e          op;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  burst_addr_decode u_decode (
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .op        (op)
  );

  burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .op  (op),
    .cur (addr_q),
    .ext (addr_in),
    .nxt (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  assign addr_out = addr_q;

endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_n,
  input logic              cnt_en_n,
  input logic              cnt_clr_n,
  input logic [ADDR_W-1:0] addr_out
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (addr_out == '0));

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr_n |=> (addr_out == '0));

  assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && !strobe_n) |=> (addr_out == $past(addr_in)));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && !cnt_en_n) |=>
      (addr_out == ADDR_W'($past(addr_out) + 1'b1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && cnt_en_n) |=> $stable(addr_out));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && !cnt_en_n && (&addr_out)) |=> (addr_out == '0));

endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr_in   (addr_in),
  .strobe_n  (strobe_n),
  .cnt_en_n  (cnt_en_n),
  .cnt_clr_n (cnt_clr_n),
  .addr_out  (addr_out)
);

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;

  localparam int W = 4;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] addr_in = '0;
  logic         strobe_n = 1'b1;
  logic         cnt_en_n = 1'b1;
  logic         cnt_clr_n = 1'b1;
  logic [W-1:0] addr_out;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [W-1:0] expv = '0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  burst_addr_ctr #(.ADDR_W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .addr_in   (addr_in),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .addr_out  (addr_out)
  );

  function automatic logic [W-1:0] model(input logic r, input logic clr_n,
      input logic stb_n, input logic en_n, input logic [W-1:0] ext,
      input logic [W-1:0] cur);
    if (r)           return '0;
    else if (!clr_n) return '0;
    else if (!stb_n) return ext;
    else if (!en_n)  return W'(cur + 1'b1);
    else             return cur;
  endfunction

  function automatic string req_of(input logic r, input logic clr_n,
      input logic stb_n, input logic en_n, input logic [W-1:0] cur);
    if (r)           return "R1";
    else if (!clr_n) return "R2";
    else if (!stb_n) return "R3";
    else if (!en_n)  return (&cur) ? "R6" : "R4";
    else             return "R5";
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, verify nothing moves before the rising edge,
  // then check the registered result at the following falling edge.
  task automatic step(input logic r, input logic clr_n, input logic stb_n,
                      input logic en_n, input logic [W-1:0] ext);
    string req;
    logic [W-1:0] prev;
    prev = expv;
    rst = r; cnt_clr_n = clr_n; strobe_n = stb_n; cnt_en_n = en_n; addr_in = ext;
    #3;
    check("R7", addr_out, prev);
    req  = req_of(r, clr_n, stb_n, en_n, prev);
    expv = model(r, clr_n, stb_n, en_n, ext, prev);
    @(negedge clk);
    check(req, addr_out, expv);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    @(negedge clk);
    @(negedge clk);
    check("R1", addr_out, '0);          // reset state
    expv = '0;

    // R1: reset dominates every other control
    step(1'b1, 1'b1, 1'b0, 1'b0, 4'h9);
    // R3: load an address, enable asserted too (load wins)
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'hA);
    // R4: increment steps
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h3);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h3);
    // R5: hold, bus changes ignored
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h7);
    // R2: clear wins over load and enable
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'h5);
    // R6: load all-ones, then increment wraps to zero
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h2);
    step(1'b0, 1'b1, 1'b1, 1'b0, 4'h2);
    // R1: reset from a non-zero address
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'h6);
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'h6);

    // Random mix, biased toward increments so wraps occur often
    for (int i = 0; i < 600; i++) begin
      int unsigned pick;
      logic r, clr_n, stb_n, en_n;
      pick  = $urandom % 100;
      r     = (pick < 3);
      clr_n = !(pick >= 3 && pick < 10);
      stb_n = !(pick >= 10 && pick < 25);
      en_n  = ($urandom % 100) < 30;
      step(r, clr_n, stb_n, en_n, W'($urandom));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule